// File: doc/BRIEF.md
# SDRAM Command Front End with Mode and Low-Power Registers

This block is the command-decoding front end of a device-side SDRAM model. On every rising clock edge it samples the chip-select, row-strobe, column-strobe and write-enable lines and turns them into one decoded command. It keeps track of which of the four banks currently has an open row, and how long ago each row was opened. It holds the burst and latency settings from the mode register, and the refresh-period and partial-array settings from the low-power register. It reports every command that breaks the protocol.

All outputs are registered. They reflect the command sampled at the previous rising edge. A command that breaks a rule gives a one-cycle error pulse and nothing else. It produces no command strobe, opens or closes no bank, and writes no register. The partial-array setting is expanded into a refresh-enable mask with one bit per quarter of each bank. A self-refresh engine placed after this block can use that mask directly.

Top module: `sdram_cmd_front`

## Requirements
- R1: With cs_n low, ras_n low, cas_n high and we_n high, an activate is decoded. If the mode register has been written since reset, act_stb is high in the next cycle and bank_open[ba] is set.
- R2: With cs_n low, ras_n high and cas_n low, a column command is decoded: a read when we_n is high, a write when we_n is low. A legal one gives rd_stb or wr_stb in the next cycle. When cs_n is high, or the lines encode no other command, no strobe is given.
- R3: With ras_n low, cas_n high and we_n low, a precharge is decoded. It closes bank ba, or every bank when addr[10] is high, and gives pre_stb. With ras_n and cas_n low and we_n high, a refresh is decoded and gives ref_stb.
- R4: A column command is flagged in either of two cases: its bank is closed, or fewer than TRCD edges (default 3) have passed since that bank's activate was sampled. A flagged command gives err high for one cycle and no strobe.
- R5: A register write (ras_n, cas_n and we_n all low) while any bank is open is flagged and leaves both registers unchanged.
- R6: An activate sampled before the first accepted mode-register write after reset is flagged, and the bank stays closed.
- R7: A register write with ba = 0 loads the mode register and gives mset_stb. The fields are:
  - addr[1:0] with addr[2] = 0 sets the burst length: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8.
  - addr[3] selects the address order: 0 is sequential, 1 is interleaved.
  - addr[6:4] sets the CAS latency: 2 or 3.
  - addr[9] selects burst read with single write.
- R8: A register write with ba = 2 loads the low-power register and gives mset_stb. addr[2:0] sets the partial-array code. addr[4:3] sets the refresh period, and all four of its values are legal.
- R9: ref_en bit 4*b+q enables quarter q of bank b. The partial-array code sets it as follows:
  - 000: all bits set.
  - 001: banks 0 and 1.
  - 010: bank 0.
  - 101: quarters 0 and 1 of bank 0.
  - 110: quarter 0 of bank 0.
- R10: The following register writes are flagged and change no register:
  - a burst-length code with addr[2] = 1;
  - a CAS latency other than 2 or 3;
  - a partial-array code of 011, 100 or 111;
  - a ba of 1 or 3.
- R11: After reset all strobes and err are low and all banks are closed. burst_len is 1, sequential order is selected, cas_lat is 2, normal burst mode is selected, rf_period is 0, pas_sel is 000, and ref_en is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (2) | Bank address / register select |
| addr | input | ADDR_W (13) | Address lines / register data |
| act_stb | output | 1 | Accepted activate |
| rd_stb | output | 1 | Accepted read |
| wr_stb | output | 1 | Accepted write |
| pre_stb | output | 1 | Precharge |
| ref_stb | output | 1 | Refresh |
| mset_stb | output | 1 | Accepted register write |
| burst_len | output | 4 | Burst length 1, 2, 4 or 8 |
| interleave | output | 1 | Interleaved address order |
| cas_lat | output | 3 | CAS latency |
| burst_rd_single_wr | output | 1 | Burst read, single write mode |
| rf_period | output | 2 | Self-refresh period code |
| pas_sel | output | 3 | Partial-array code |
| bank_open | output | NBANK (4) | Per-bank open-row flags |
| ref_en | output | NBANK*QPB (16) | Self-refresh enable per quarter bank |
| err | output | 1 | Protocol violation pulse |

## Verification
The hardest situation to reach is a column command that hits an open bank exactly one edge before or at the end of the row-to-column window. Random traffic rarely lands there, because it keeps opening, reopening and closing banks. The bench therefore issues directed reads one, two and three edges after an activate, and then reopens the same bank so that its window restarts. A second hard case is a register write refused only because one bank is still open. The stimulus reaches it by opening a single bank after a legal mode write, and later closes all banks at once with a precharge that has addr[10] set.

// File: rtl/sdcf_pkg.sv
package sdcf_pkg;

  typedef enum logic [2:0] {
    C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_MSET
  } cmd_e;

  typedef struct packed {
    logic [1:0] bl_code;
    logic       ilv;
    logic [2:0] cl;
    logic       brsw;
  } mode_t;

  typedef struct packed {
    logic [2:0] pas;
    logic [1:0] period;
  } lp_t;

  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    cmd_e c;
    c = C_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  c = C_ACT;
        3'b101:  c = C_RD;
        3'b100:  c = C_WR;
        3'b010:  c = C_PRE;
        3'b001:  c = C_REF;
        3'b000:  c = C_MSET;
        default: c = C_NOP;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/sdcf_bank_tracker.sv
module sdcf_bank_tracker #(
  parameter int NBANK = 4,
  parameter int TRCD  = 3,
  parameter int BA_W  = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_go,
  input  logic             pre_go,
  input  logic             pre_all,
  input  logic [BA_W-1:0]  ba,
  output logic [NBANK-1:0] open_q,
  output logic [NBANK-1:0] col_ok
);
  localparam int CW = $clog2(TRCD + 1);
  localparam logic [CW-1:0] LOAD = CW'(TRCD - 1);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic          open_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          hit;

    assign hit = (ba == BA_W'(b));

    always_comb begin
      open_d = open_q[b];
      cnt_d  = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
      if (act_go && hit) begin
        open_d = 1'b1;
        cnt_d  = LOAD;
      end
      if (pre_go && (pre_all || hit)) open_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[b] <= 1'b0;
        cnt_q     <= '0;
      end else begin
        open_q[b] <= open_d;
        cnt_q     <= cnt_d;
      end
    end

    assign col_ok[b] = open_q[b] && (cnt_q == '0);
  end

endmodule

// File: rtl/sdcf_mode_regs.sv
module sdcf_mode_regs
  import sdcf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic       lp_we,
  input  logic [9:0] a,
  output logic       mode_ok,
  output logic       lp_ok,
  output mode_t      mode_q,
  output lp_t        lp_q,
  output logic       mode_seen
);
  mode_t mode_d;
  lp_t   lp_d;
  logic  seen_d;
  logic  unused_bits;

  assign unused_bits = ^a[8:7];

  always_comb begin
    mode_ok = !a[2] && ((a[6:4] == 3'd2) || (a[6:4] == 3'd3));
    case (a[2:0])
      3'b000, 3'b001, 3'b010, 3'b101, 3'b110: lp_ok = 1'b1;
      default:                                lp_ok = 1'b0;
    endcase
  end

  always_comb begin
    mode_d = mode_q;
    lp_d   = lp_q;
    seen_d = mode_seen;
    if (mode_we) begin
      mode_d = '{bl_code: a[1:0], ilv: a[3], cl: a[6:4], brsw: a[9]};
      seen_d = 1'b1;
    end
    if (lp_we) lp_d = '{pas: a[2:0], period: a[4:3]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '{bl_code: 2'd0, ilv: 1'b0, cl: 3'd2, brsw: 1'b0};
      lp_q      <= '{pas: 3'd0, period: 2'd0};
      mode_seen <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      lp_q      <= lp_d;
      mode_seen <= seen_d;
    end
  end

endmodule

// File: rtl/sdcf_ref_mask.sv
module sdcf_ref_mask #(
  parameter int NBANK = 4,
  parameter int QPB   = 4
) (
  input  logic [2:0]           pas,
  output logic [NBANK*QPB-1:0] en
);
  localparam int HALF = (QPB / 2 < 1) ? 1 : QPB / 2;
  localparam int QTR  = (QPB / 4 < 1) ? 1 : QPB / 4;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam bit IS_B0 = (b == 0);
    localparam bit LOW2  = (b < 2);
    logic bank_on;

    always_comb begin
      case (pas)
        3'b000:                 bank_on = 1'b1;
        3'b001:                 bank_on = LOW2;
        3'b010, 3'b101, 3'b110: bank_on = IS_B0;
        default:                bank_on = 1'b1;
      endcase
    end

    for (genvar q = 0; q < QPB; q++) begin : g_quarter
      localparam bit IN_HALF = (q < HALF);
      localparam bit IN_QTR  = (q < QTR);
      assign en[b*QPB+q] = bank_on &&
                           ((pas == 3'b101) ? IN_HALF :
                            (pas == 3'b110) ? IN_QTR  : 1'b1);
    end
  end

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdcf_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int QPB    = 4,
  parameter int ADDR_W = 13,
  parameter int TRCD   = 3,
  parameter int BA_W   = $clog2(NBANK)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic [ADDR_W-1:0]    addr,
  output logic                 act_stb,
  output logic                 rd_stb,
  output logic                 wr_stb,
  output logic                 pre_stb,
  output logic                 ref_stb,
  output logic                 mset_stb,
  output logic [3:0]           burst_len,
  output logic                 interleave,
  output logic [2:0]           cas_lat,
  output logic                 burst_rd_single_wr,
  output logic [1:0]           rf_period,
  output logic [2:0]           pas_sel,
  output logic [NBANK-1:0]     bank_open,
  output logic [NBANK*QPB-1:0] ref_en,
  output logic                 err
);
  cmd_e             cmd;
  logic [NBANK-1:0] col_ok;
  logic             mode_ok, lp_ok, mode_seen;
  mode_t            mode_q;
  lp_t              lp_q;
  logic             act_go, rd_go, wr_go, pre_go, ref_go;
  logic             mode_we, lp_we, col_cmd, err_d;
  logic             unused_addr;

  assign unused_addr = ^addr[ADDR_W-1:11];
  assign cmd = decode_cmd(cs_n, ras_n, cas_n, we_n);

  always_comb begin
    col_cmd = (cmd == C_RD) || (cmd == C_WR);
    act_go  = (cmd == C_ACT) && mode_seen;
    rd_go   = (cmd == C_RD) && col_ok[ba];
    wr_go   = (cmd == C_WR) && col_ok[ba];
    pre_go  = (cmd == C_PRE);
    ref_go  = (cmd == C_REF);
    mode_we = (cmd == C_MSET) && (bank_open == '0) &&
              (ba == BA_W'(0)) && mode_ok;
    lp_we   = (cmd == C_MSET) && (bank_open == '0) &&
              (ba == BA_W'(2)) && lp_ok;
    err_d   = ((cmd == C_ACT) && !mode_seen) ||
              (col_cmd && !col_ok[ba]) ||
              ((cmd == C_MSET) && !(mode_we || lp_we));
  end

  sdcf_bank_tracker #(.NBANK(NBANK), .TRCD(TRCD), .BA_W(BA_W)) u_banks (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_go  (act_go),
    .pre_go  (pre_go),
    .pre_all (addr[10]),
    .ba      (ba),
    .open_q  (bank_open),
    .col_ok  (col_ok)
  );

  sdcf_mode_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_we   (mode_we),
    .lp_we     (lp_we),
    .a         (addr[9:0]),
    .mode_ok   (mode_ok),
    .lp_ok     (lp_ok),
    .mode_q    (mode_q),
    .lp_q      (lp_q),
    .mode_seen (mode_seen)
  );

  sdcf_ref_mask #(.NBANK(NBANK), .QPB(QPB)) u_mask (
    .pas (lp_q.pas),
    .en  (ref_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_stb  <= 1'b0;
      rd_stb   <= 1'b0;
      wr_stb   <= 1'b0;
      pre_stb  <= 1'b0;
      ref_stb  <= 1'b0;
      mset_stb <= 1'b0;
      err      <= 1'b0;
    end else begin
      act_stb  <= act_go;
      rd_stb   <= rd_go;
      wr_stb   <= wr_go;
      pre_stb  <= pre_go;
      ref_stb  <= ref_go;
      mset_stb <= mode_we || lp_we;
      err      <= err_d;
    end
  end

  assign burst_len          = 4'b0001 << mode_q.bl_code;
  assign interleave         = mode_q.ilv;
  assign cas_lat            = mode_q.cl;
  assign burst_rd_single_wr = mode_q.brsw;
  assign rf_period          = lp_q.period;
  assign pas_sel            = lp_q.pas;

endmodule

// File: rtl/sdcf_checker.sv
module sdcf_checker #(
  parameter int NBANK = 4,
  parameter int QPB   = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 act_stb,
  input logic                 rd_stb,
  input logic                 wr_stb,
  input logic                 pre_stb,
  input logic                 ref_stb,
  input logic                 mset_stb,
  input logic [3:0]           burst_len,
  input logic                 interleave,
  input logic [2:0]           cas_lat,
  input logic                 burst_rd_single_wr,
  input logic [1:0]           rf_period,
  input logic [2:0]           pas_sel,
  input logic [NBANK-1:0]     bank_open,
  input logic [NBANK*QPB-1:0] ref_en,
  input logic                 err
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_stb, rd_stb, wr_stb, pre_stb, ref_stb, mset_stb})); // R2

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    act_stb |-> (bank_open != '0)); // R1

  AST_COL_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> (bank_open != '0)); // R4

  AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !(act_stb || rd_stb || wr_stb || pre_stb || ref_stb || mset_stb)); // R4

  AST_MSET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mset_stb |-> (bank_open == '0)); // R5

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mset_stb |-> $stable({burst_len, interleave, cas_lat, burst_rd_single_wr,
                           rf_period, pas_sel})); // R10

  AST_CL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat == 3'd2) || (cas_lat == 3'd3)); // R7

  AST_BURST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(burst_len) == 1); // R7

  AST_BANK0_REFRESHED: assert property (@(posedge clk) disable iff (!rst_n)
    ref_en[0]); // R9

endmodule

bind sdram_cmd_front sdcf_checker #(.NBANK(NBANK), .QPB(QPB)) u_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .act_stb            (act_stb),
  .rd_stb             (rd_stb),
  .wr_stb             (wr_stb),
  .pre_stb            (pre_stb),
  .ref_stb            (ref_stb),
  .mset_stb           (mset_stb),
  .burst_len          (burst_len),
  .interleave         (interleave),
  .cas_lat            (cas_lat),
  .burst_rd_single_wr (burst_rd_single_wr),
  .rf_period          (rf_period),
  .pas_sel            (pas_sel),
  .bank_open          (bank_open),
  .ref_en             (ref_en),
  .err                (err)
);

// File: tb/tb_sdram_cmd_front.sv
`timescale 1ns/1ps
module tb_sdram_cmd_front;
  localparam int TRCD = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic        act_stb, rd_stb, wr_stb, pre_stb, ref_stb, mset_stb;
  logic [3:0]  burst_len;
  logic        interleave, burst_rd_single_wr, err;
  logic [2:0]  cas_lat, pas_sel;
  logic [1:0]  rf_period;
  logic [3:0]  bank_open;
  logic [15:0] ref_en;

  always #2 clk = ~clk;

  sdram_cmd_front dut (.*);

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // behavioural reference state
  int m_open[4];
  int m_act_at[4];
  int edge_n;
  bit m_seen;
  int m_bl, m_ilv, m_cl, m_op, m_pas, m_per;
  int e_act, e_rd, e_wr, e_pre, e_ref, e_mset, e_err;
  string err_tag;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_mask(input int pas);
    int m = 0;
    for (int b = 0; b < 4; b++)
      for (int q = 0; q < 4; q++) begin
        bit on;
        case (pas)
          0: on = 1;
          1: on = (b < 2);
          2: on = (b == 0);
          5: on = (b == 0) && (q < 2);
          6: on = (b == 0) && (q == 0);
          default: on = 1;
        endcase
        if (on) m |= (1 << (b * 4 + q));
      end
    return m;
  endfunction

  task automatic compare_all();
    int om = 0;
    for (int b = 0; b < 4; b++) if (m_open[b] != 0) om |= (1 << b);
    chk("R1", "act_stb", act_stb, e_act);
    chk("R1", "bank_open", bank_open, om);
    chk("R2", "rd_stb", rd_stb, e_rd);
    chk("R2", "wr_stb", wr_stb, e_wr);
    chk("R3", "pre_stb", pre_stb, e_pre);
    chk("R3", "ref_stb", ref_stb, e_ref);
    chk("R7", "mset_stb", mset_stb, e_mset);
    chk(err_tag, "err", err, e_err);
    chk("R7", "burst_len", burst_len, m_bl);
    chk("R7", "interleave", interleave, m_ilv);
    chk("R7", "cas_lat", cas_lat, m_cl);
    chk("R7", "burst_rd_single_wr", burst_rd_single_wr, m_op);
    chk("R8", "rf_period", rf_period, m_per);
    chk("R8", "pas_sel", pas_sel, m_pas);
    chk("R9", "ref_en", ref_en, exp_mask(m_pas));
  endtask

  task automatic model_step(input bit cs, input bit r, input bit c, input bit w,
                            input int b, input logic [12:0] a);
    e_act = 0; e_rd = 0; e_wr = 0; e_pre = 0; e_ref = 0; e_mset = 0; e_err = 0;
    if (!cs) begin
      case ({r, c, w})
        3'b011: if (!m_seen) e_err = 1;
                else begin m_open[b] = 1; m_act_at[b] = edge_n; e_act = 1; end
        3'b101, 3'b100:
          if (m_open[b] != 0 && edge_n - m_act_at[b] >= TRCD) begin
            if (w) e_rd = 1; else e_wr = 1;
          end else e_err = 1;
        3'b010: begin
          e_pre = 1;
          if (a[10]) for (int i = 0; i < 4; i++) m_open[i] = 0;
          else m_open[b] = 0;
        end
        3'b001: e_ref = 1;
        3'b000: begin
          bit any = 0;
          for (int i = 0; i < 4; i++) if (m_open[i] != 0) any = 1;
          if (any) e_err = 1;
          else if (b == 0) begin
            if (a[2] || !(a[6:4] == 3'd2 || a[6:4] == 3'd3)) e_err = 1;
            else begin
              m_bl = 1 << a[1:0]; m_ilv = a[3]; m_cl = a[6:4]; m_op = a[9];
              m_seen = 1; e_mset = 1;
            end
          end else if (b == 2) begin
            if (a[2:0] == 3 || a[2:0] == 4 || a[2:0] == 7) e_err = 1;
            else begin m_pas = a[2:0]; m_per = a[4:3]; e_mset = 1; end
          end else e_err = 1;
        end
        default: ;
      endcase
    end
    edge_n++;
  endtask

  // one command: check previous results at the falling edge, then drive
  task automatic cyc(input bit cs, input bit r, input bit c, input bit w,
                     input int b, input logic [12:0] a, input string tag);
    @(negedge clk);
    compare_all();
    cs_n = cs; ras_n = r; cas_n = c; we_n = w; ba = 2'(b); addr = a;
    err_tag = tag;
    model_step(cs, r, c, w, b, a);
  endtask

  task automatic reset_model();
    for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_act_at[i] = 0; end
    edge_n = 0; m_seen = 0;
    m_bl = 1; m_ilv = 0; m_cl = 2; m_op = 0; m_pas = 0; m_per = 0;
    e_act = 0; e_rd = 0; e_wr = 0; e_pre = 0; e_ref = 0; e_mset = 0; e_err = 0;
    err_tag = "R11";
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    ba = 2'd0; addr = '0;
    reset_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state compared by the first cyc call
    cyc(1, 1, 1, 1, 0, 13'h0, "R11");
    cyc(1, 0, 0, 0, 0, 13'h0, "R2");          // deselected: nothing
    cyc(0, 0, 1, 1, 1, 13'h0, "R6");          // activate before mode write
    cyc(0, 0, 0, 0, 0, 13'h004, "R10");       // burst code reserved
    cyc(0, 0, 0, 0, 0, 13'h042, "R10");       // CAS latency 4 reserved
    cyc(0, 0, 0, 0, 1, 13'h020, "R10");       // register select 1
    cyc(0, 0, 0, 0, 2, 13'h003, "R10");       // partial code 011
    cyc(0, 0, 0, 0, 0, 13'h23B, "R7");        // BL8, interleave, CL3, brsw
    for (int p = 0; p < 8; p++)
      if (p != 3 && p != 4 && p != 7)
        cyc(0, 0, 0, 0, 2, 13'(p | (p[1:0] << 3)), "R8");  // R9 masks
    cyc(0, 0, 0, 0, 2, 13'h006, "R8");        // quarter of bank 0
    cyc(0, 0, 1, 1, 2, 13'h0, "R1");
    cyc(0, 1, 0, 1, 2, 13'h0, "R4");          // one edge after activate
    cyc(0, 1, 0, 0, 2, 13'h0, "R4");          // two edges
    cyc(0, 1, 0, 1, 2, 13'h0, "R4");          // three edges: legal read
    cyc(0, 1, 0, 0, 2, 13'h0, "R4");          // legal write
    cyc(0, 1, 0, 1, 1, 13'h0, "R4");          // closed bank
    cyc(0, 0, 1, 1, 2, 13'h0, "R1");          // reopen restarts window
    cyc(0, 1, 0, 0, 2, 13'h0, "R4");
    cyc(0, 0, 0, 0, 0, 13'h020, "R5");        // write while bank open
    cyc(0, 0, 1, 1, 3, 13'h0, "R1");
    cyc(0, 0, 1, 0, 3, 13'h0, "R3");          // close bank 3 only
    cyc(0, 0, 0, 1, 0, 13'h0, "R3");          // refresh
    cyc(0, 0, 1, 0, 0, 13'h400, "R3");        // close all
    cyc(0, 0, 0, 0, 0, 13'h020, "R7");        // BL1, CL2
    cyc(0, 1, 1, 0, 0, 13'h0, "R2");          // no-command encoding
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom % 9;
      int b = $urandom % 4;
      logic [12:0] a = 13'($urandom);
      case (k)
        0, 1: cyc(0, 0, 1, 1, b, a, "R1");
        2:    cyc(0, 1, 0, 1, b, a, "R4");
        3:    cyc(0, 1, 0, 0, b, a, "R4");
        4:    cyc(0, 0, 1, 0, b, a, "R3");
        5:    cyc(0, 0, 0, 1, b, a, "R3");
        6: begin
          if ($urandom % 2 == 0) begin a[2] = 1'b0; a[6:4] = 3'(2 + $urandom % 2); end
          cyc(0, 0, 0, 0, b, a, "R10");
        end
        7:    cyc(0, 0, 0, 0, 2, a, "R8");
        default: cyc(1, 0, 1, 1, b, a, "R2");
      endcase
    end
    cyc(1, 1, 1, 1, 0, 13'h0, "R2");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule